// File: doc/BRIEF.md
# Inter-Port Semaphore Flag Unit

This block holds eight hardware token flags that two independent ports (left and right) share to decide who owns a shared resource. A port picks a flag with its semaphore select strobe and a 3-bit index. It claims the flag by writing a 0 on data bit 0 and gives it back by writing a 1. It then reads the same index to learn whether it now holds the token. Claiming always follows this pattern: write, then read back to confirm.

Each port keeps one request flop for each flag. A claim made while the other port holds the token is not lost. It stays pending and turns into ownership on its own as soon as the holder releases. When both ports claim a free flag in the same cycle, the left port wins.

Top module: `sem_flag_unit`

## Requirements
- R1: After reset all eight flags are free and no request is pending. Both read outputs are 16'hFFFF until the first read.
- R2: A write with data bit 0 = 0 to a free flag grants it to the writing port. A read of that index in the next cycle returns 16'h0000 on that port and 16'hFFFF on the other port.
- R3: A read (select = 1, write = 0) of index k loads the read output one clock later. The value is 16'h0000 if the reading port holds flag k and 16'hFFFF otherwise. The output keeps its value in cycles without a read.
- R4: Only data bit 0 of a write matters. Bits 15..1 have no effect on a claim or a release.
- R5: A write of 1 from the holder releases the flag. A write of 1 from a port that neither holds nor requests the flag changes nothing.
- R6: If both ports claim a free flag in the same cycle, the left port is granted and the right request stays pending.
- R7: A claim made while the other port holds the flag stays pending, so a read returns 16'hFFFF. The claim is granted at the clock edge that ends the holder's release write, so a read in the next cycle returns 16'h0000.
- R8: A write of 1 from a port with a pending claim withdraws that claim. A later release by the holder then leaves the flag free.
- R9: The eight flags are independent. Operations on one index do not change ownership of any other index.
- R10: With select = 0, the write, index and data inputs of that port are ignored.
- R11: A holder that writes 0 again keeps the flag, even if the other port claims it in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lft_sel | input | 1 | Left semaphore select strobe |
| lft_wr | input | 1 | Left write (1) or read (0) |
| lft_idx | input | 3 | Left flag index |
| lft_wdata | input | 16 | Left write data; only bit 0 is used |
| lft_rdata | output | 16 | Left read result, registered |
| rgt_sel | input | 1 | Right semaphore select strobe |
| rgt_wr | input | 1 | Right write (1) or read (0) |
| rgt_idx | input | 3 | Right flag index |
| rgt_wdata | input | 16 | Right write data; only bit 0 is used |
| rgt_rdata | output | 16 | Right read result, registered |

## Verification
Ownership changes at the clock edge that ends a write, so it is visible to a read issued in the very next cycle. The read result itself appears one edge after the read strobe. A claim or release issued in cycle c therefore shows on the read output at the edge after cycle c+1. The scoreboard tags each expected read value with the cycle count of the edge that loads it. The monitor pops the entry only at the falling edge after that count is reached, so every comparison happens half a period after the register has updated.

// File: rtl/sem_pkg.sv
package sem_pkg;

    localparam int SEM_COUNT  = 8;
    localparam int SEM_IDX_W  = $clog2(SEM_COUNT);
    localparam int SEM_DATA_W = 16;

    typedef enum logic [1:0] {
        HOLD_NONE  = 2'd0,
        HOLD_LEFT  = 2'd1,
        HOLD_RIGHT = 2'd2
    } holder_e;

    typedef struct packed {
        logic                 sel;
        logic                 wr;
        logic [SEM_IDX_W-1:0] idx;
        logic                 bit0;
    } sem_cmd_t;

    // Next request flop value: a claim sets, a release clears.
    function automatic logic req_update(input logic cur, input logic set_r, input logic clr_r);
        logic nxt;
        nxt = cur;
        if (set_r)      nxt = 1'b1;
        else if (clr_r) nxt = 1'b0;
        return nxt;
    endfunction

    // Ownership resolution: the holder keeps the token while its request stands,
    // otherwise the left request wins over the right one.
    function automatic holder_e resolve_holder(input holder_e cur,
                                               input logic req_left,
                                               input logic req_right);
        holder_e nxt;
        if (cur == HOLD_LEFT && req_left)        nxt = HOLD_LEFT;
        else if (cur == HOLD_RIGHT && req_right) nxt = HOLD_RIGHT;
        else if (req_left)                       nxt = HOLD_LEFT;
        else if (req_right)                      nxt = HOLD_RIGHT;
        else                                     nxt = HOLD_NONE;
        return nxt;
    endfunction

endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode
    import sem_pkg::*;
#(
    parameter int NUM_SEM = SEM_COUNT,
    parameter int DATA_W  = SEM_DATA_W,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [NUM_SEM-1:0] set_req,
    output logic [NUM_SEM-1:0] clr_req,
    output logic               rd_stb
);
    logic unused_wdata_hi;
    logic claim;
    logic give_back;

    assign unused_wdata_hi = ^wdata[DATA_W-1:1];
    assign claim     = sel && wr && !wdata[0];
    assign give_back = sel && wr &&  wdata[0];
    assign rd_stb    = sel && !wr;

    for (genvar k = 0; k < NUM_SEM; k++) begin : g_dec
        assign set_req[k] = claim     && (idx == IDX_W'(k));
        assign clr_req[k] = give_back && (idx == IDX_W'(k));
    end
endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_l,
    input  logic clr_l,
    input  logic set_r,
    input  logic clr_r,
    output logic held_l,
    output logic held_r
);
    logic    req_l_q, req_r_q;
    logic    req_l_d, req_r_d;
    holder_e holder_q, holder_d;

    always_comb begin
        req_l_d  = req_update(req_l_q, set_l, clr_l);
        req_r_d  = req_update(req_r_q, set_r, clr_r);
        holder_d = resolve_holder(holder_q, req_l_d, req_r_d);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_l_q  <= 1'b0;
            req_r_q  <= 1'b0;
            holder_q <= HOLD_NONE;
        end else begin
            req_l_q  <= req_l_d;
            req_r_q  <= req_r_d;
            holder_q <= holder_d;
        end
    end

    assign held_l = (holder_q == HOLD_LEFT);
    assign held_r = (holder_q == HOLD_RIGHT);
endmodule

// File: rtl/sem_read_port.sv
module sem_read_port
    import sem_pkg::*;
#(
    parameter int NUM_SEM = SEM_COUNT,
    parameter int DATA_W  = SEM_DATA_W,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_stb,
    input  logic [IDX_W-1:0]   idx,
    input  logic [NUM_SEM-1:0] held,
    output logic [DATA_W-1:0]  rdata
);
    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '1;
        else if (rd_stb)
            rdata <= held[idx] ? '0 : '1;
    end
endmodule

// File: rtl/sem_flag_unit.sv
module sem_flag_unit
    import sem_pkg::*;
#(
    parameter int NUM_SEM = SEM_COUNT,
    parameter int DATA_W  = SEM_DATA_W,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lft_sel,
    input  logic              lft_wr,
    input  logic [IDX_W-1:0]  lft_idx,
    input  logic [DATA_W-1:0] lft_wdata,
    output logic [DATA_W-1:0] lft_rdata,
    input  logic              rgt_sel,
    input  logic              rgt_wr,
    input  logic [IDX_W-1:0]  rgt_idx,
    input  logic [DATA_W-1:0] rgt_wdata,
    output logic [DATA_W-1:0] rgt_rdata
);
    logic [NUM_SEM-1:0] set_l, clr_l, set_r, clr_r;
    logic [NUM_SEM-1:0] held_l, held_r;
    logic               rd_l, rd_r;

    sem_port_decode #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_dec_l (
        .sel(lft_sel), .wr(lft_wr), .idx(lft_idx), .wdata(lft_wdata),
        .set_req(set_l), .clr_req(clr_l), .rd_stb(rd_l)
    );

    sem_port_decode #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_dec_r (
        .sel(rgt_sel), .wr(rgt_wr), .idx(rgt_idx), .wdata(rgt_wdata),
        .set_req(set_r), .clr_req(clr_r), .rd_stb(rd_r)
    );

    for (genvar k = 0; k < NUM_SEM; k++) begin : g_flag
        sem_flag_cell u_cell (
            .clk(clk), .rst(rst),
            .set_l(set_l[k]), .clr_l(clr_l[k]),
            .set_r(set_r[k]), .clr_r(clr_r[k]),
            .held_l(held_l[k]), .held_r(held_r[k])
        );
    end

    sem_read_port #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_l (
        .clk(clk), .rst(rst), .rd_stb(rd_l), .idx(lft_idx),
        .held(held_l), .rdata(lft_rdata)
    );

    sem_read_port #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_r (
        .clk(clk), .rst(rst), .rd_stb(rd_r), .idx(rgt_idx),
        .held(held_r), .rdata(rgt_rdata)
    );
endmodule

// File: rtl/sem_flag_checker.sv
module sem_flag_checker #(
    parameter int NUM_SEM = 8,
    parameter int DATA_W  = 16,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input logic               clk,
    input logic               rst,
    input logic               lft_sel,
    input logic               lft_wr,
    input logic [IDX_W-1:0]   lft_idx,
    input logic [DATA_W-1:0]  lft_wdata,
    input logic [DATA_W-1:0]  lft_rdata,
    input logic               rgt_sel,
    input logic               rgt_wr,
    input logic [IDX_W-1:0]   rgt_idx,
    input logic [DATA_W-1:0]  rgt_rdata,
    input logic [NUM_SEM-1:0] held_l,
    input logic [NUM_SEM-1:0] held_r
);
    // R2 / R6: a left claim on a flag the right side does not hold is granted
    assert_left_claim_R2: assert property (@(posedge clk) disable iff (rst)
        (lft_sel && lft_wr && !lft_wdata[0] && !held_r[lft_idx]) |=> held_l[$past(lft_idx)]);

    // R5: a left release always leaves the left side without that flag
    assert_left_release_R5: assert property (@(posedge clk) disable iff (rst)
        (lft_sel && lft_wr && lft_wdata[0]) |=> !held_l[$past(lft_idx)]);

    // R11: left ownership is never lost without a left release write
    assert_left_keep_R11: assert property (@(posedge clk) disable iff (rst)
        !(lft_sel && lft_wr && lft_wdata[0]) |=> (($past(held_l) & ~held_l) == '0));

    // R3: a read result is either all zeros or all ones
    assert_read_code_R3: assert property (@(posedge clk) disable iff (rst)
        (lft_sel && !lft_wr) |=> (lft_rdata == '0 || lft_rdata == '1));

    // R3: right read output holds when no read is issued
    assert_read_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !(rgt_sel && !rgt_wr) |=> $stable(rgt_rdata));

    // R6: both sides never hold the same flag
    assert_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        (held_l & held_r) == '0);
endmodule

bind sem_flag_unit sem_flag_checker #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst),
    .lft_sel(lft_sel), .lft_wr(lft_wr), .lft_idx(lft_idx),
    .lft_wdata(lft_wdata), .lft_rdata(lft_rdata),
    .rgt_sel(rgt_sel), .rgt_wr(rgt_wr), .rgt_idx(rgt_idx),
    .rgt_rdata(rgt_rdata),
    .held_l(held_l), .held_r(held_r)
);

// File: tb/tb_sem_flag_unit.sv
module tb_sem_flag_unit;
    localparam logic [15:0] OWN  = 16'h0000;
    localparam logic [15:0] NOWN = 16'hFFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lft_sel = 0, lft_wr = 0, rgt_sel = 0, rgt_wr = 0;
    logic [2:0]  lft_idx = 0, rgt_idx = 0;
    logic [15:0] lft_wdata = 0, rgt_wdata = 0;
    logic [15:0] lft_rdata, rgt_rdata;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct {
        bit          rgt;
        logic [15:0] val;
        string       tag;
        int          due;
    } exp_t;
    exp_t sb[$];

    sem_flag_unit dut (
        .clk(clk), .rst(rst),
        .lft_sel(lft_sel), .lft_wr(lft_wr), .lft_idx(lft_idx),
        .lft_wdata(lft_wdata), .lft_rdata(lft_rdata),
        .rgt_sel(rgt_sel), .rgt_wr(rgt_wr), .rgt_idx(rgt_idx),
        .rgt_wdata(rgt_wdata), .rgt_rdata(rgt_rdata)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compares each expected read once its loading edge has passed
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, e.rgt ? rgt_rdata : lft_rdata, e.val);
        end
    end

    task automatic idle();
        lft_sel = 0; lft_wr = 0; lft_wdata = 16'h0;
        rgt_sel = 0; rgt_wr = 0; rgt_wdata = 16'h0;
    endtask

    task automatic lop(bit wr, logic [2:0] idx, logic [15:0] d);
        lft_sel = 1; lft_wr = wr; lft_idx = idx; lft_wdata = d;
    endtask

    task automatic rop(bit wr, logic [2:0] idx, logic [15:0] d);
        rgt_sel = 1; rgt_wr = wr; rgt_idx = idx; rgt_wdata = d;
    endtask

    // driver: issue a read and push the value due one edge later
    task automatic lrd(logic [2:0] idx, logic [15:0] v, string tag);
        lop(0, idx, 16'h0);
        sb.push_back('{0, v, tag, cyc + 1});
    endtask

    task automatic rrd(logic [2:0] idx, logic [15:0] v, string tag);
        rop(0, idx, 16'h0);
        sb.push_back('{1, v, tag, cyc + 1});
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check("R1 reset left rdata", lft_rdata, NOWN);
        check("R1 reset right rdata", rgt_rdata, NOWN);

        lrd(3'd0, NOWN, "R1 left idx0 free"); rrd(3'd7, NOWN, "R1 right idx7 free"); tick();

        // claim with upper data bits set (R4)
        lop(1, 3'd2, 16'hFFFE); tick();
        lrd(3'd2, OWN, "R2 R4 left owns idx2"); rrd(3'd2, NOWN, "R2 right not owner idx2"); tick();

        // R7: right claim while left holds stays pending
        rop(1, 3'd2, 16'h0000); tick();
        rrd(3'd2, NOWN, "R7 right pending idx2"); lrd(3'd2, OWN, "R7 left still owns idx2"); tick();

        // release; right granted at same edge
        lop(1, 3'd2, 16'h0001); tick();
        rrd(3'd2, OWN, "R7 right granted after release"); lrd(3'd2, NOWN, "R5 left released idx2"); tick();

        // right release with upper bits (R4)
        rop(1, 3'd2, 16'hAAAB); tick();
        lrd(3'd2, NOWN, "R4 idx2 free left view"); rrd(3'd2, NOWN, "R4 R5 right released idx2"); tick();

        // R6: simultaneous claim, left wins
        lop(1, 3'd5, 16'h0); rop(1, 3'd5, 16'h0); tick();
        lrd(3'd5, OWN, "R6 left wins idx5"); rrd(3'd5, NOWN, "R6 right loses idx5"); tick();

        // R8: right withdraws pending claim, then left releases
        rop(1, 3'd5, 16'h1); tick();
        lop(1, 3'd5, 16'h1); tick();
        rrd(3'd5, NOWN, "R8 withdrawn stays free"); lrd(3'd5, NOWN, "R8 left released idx5"); tick();

        // R10: write pins with select low are ignored
        lft_sel = 0; lft_wr = 1; lft_idx = 3'd3; lft_wdata = 16'h0; tick();
        lrd(3'd3, NOWN, "R10 unselected write ignored"); tick();

        // R9: independent flags
        lop(1, 3'd0, 16'h0); rop(1, 3'd1, 16'h0); tick();
        lop(1, 3'd7, 16'h0); tick();
        lrd(3'd0, OWN, "R9 left owns idx0"); rrd(3'd1, OWN, "R9 right owns idx1"); tick();
        lrd(3'd1, NOWN, "R9 left not idx1"); rrd(3'd7, NOWN, "R9 right not idx7"); tick();
        lrd(3'd7, OWN, "R9 left owns idx7"); rrd(3'd4, NOWN, "R9 idx4 untouched"); tick();

        // R5: write 1 from a non-holder with no request changes nothing
        rop(1, 3'd7, 16'h1); tick();
        lrd(3'd7, OWN, "R5 non-holder release ignored"); tick();

        // R11: holder re-claims while right claims
        lop(1, 3'd0, 16'h0); rop(1, 3'd0, 16'h0); tick();
        lrd(3'd0, OWN, "R11 left keeps idx0"); rrd(3'd0, NOWN, "R11 right pending idx0"); tick();
        lop(1, 3'd0, 16'h1); tick();
        rrd(3'd0, OWN, "R7 right granted idx0"); lrd(3'd0, NOWN, "R5 left gave idx0"); tick();

        // R3: outputs hold with no read
        tick(); tick();
        check("R3 left rdata held", lft_rdata, NOWN);
        check("R3 right rdata held", rgt_rdata, OWN);

        tick();
        if (sb.size() != 0) begin
            failures++;
            $display("FAIL R3 scoreboard left %0d items actual=%0d expected=0", sb.size(), sb.size());
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule